// File: doc/BRIEF.md
# Single-Digit Decimal Adder with Seven-Segment Drive

This combinational block adds two decimal digits and a carry bit. Each digit arrives as a 4-bit binary-coded decimal value. The block forms the 5-bit binary total T = X + Y + cin and exposes it as a raw 4-bit sum with a carry-out. It also converts T into a two-digit decimal result, a tens digit and a ones digit, covering 00 through 19.

Four seven-segment drivers show the two operand digits and the two result digits. The segments are active low and ordered {g,f,e,d,c,b,a}. The tens digit is always shown, so a leading zero appears for results below ten. When either operand is not a decimal digit, an error flag rises and all four displays show a dash. The flag does not affect the raw binary sum. The block has no clock, and every output follows its inputs directly.

Top module: `bcd_digit_adder`

## Requirements
- R1: `{raw_cout, raw_sum}` equals X + Y + cin as a 5-bit binary value for every input combination, including operands above nine.
- R2: With both operands valid and T no greater than 9, `sum_tens` is 0 and `sum_ones` equals T.
- R3: With both operands valid and T between 10 and 19, `sum_tens` is 1 and `sum_ones` is T − 10. This includes totals of 16 to 19, where the 4-bit raw sum wraps past 15.
- R4: `digit_err` is 1 exactly when X > 9 or Y > 9.
- R5: With no error, `seg_x` and `seg_y` carry the active-low pattern {g,f,e,d,c,b,a} of their digit. The values are 0:7'h40, 1:7'h79, 2:7'h24, 3:7'h30, 4:7'h19, 5:7'h12, 6:7'h02, 7:7'h78, 8:7'h00 and 9:7'h10.
- R6: With no error, `seg_tens` and `seg_ones` carry the R5 patterns of the two result digits. The tens display shows 7'h40 (a zero) for results below ten.
- R7: While `digit_err` is 1, all four segment outputs equal 7'h3F, which lights segment g only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | 4 | First decimal operand |
| y_in | input | 4 | Second decimal operand |
| cin | input | 1 | Incoming carry |
| raw_sum | output | 4 | Low four bits of X + Y + cin |
| raw_cout | output | 1 | Carry out of the binary addition |
| sum_tens | output | 4 | Tens digit of the decimal result (0 or 1) |
| sum_ones | output | 4 | Ones digit of the decimal result |
| digit_err | output | 1 | An operand is above nine |
| seg_x | output | 7 | Active-low segments showing X |
| seg_y | output | 7 | Active-low segments showing Y |
| seg_tens | output | 7 | Active-low segments showing the tens digit |
| seg_ones | output | 7 | Active-low segments showing the ones digit |

## Verification
The main corner is the band of totals from 16 to 19. There the raw 4-bit sum wraps to 0 through 3, so a correction that ignores the carry-out would report 00 to 03 instead of 16 to 19. Totals of exactly 9 and 10 test the threshold: an off-by-one comparison would either send 9 to the tens digit or leave 10 as the invalid ones digit 1010. Operands of exactly 9 and 10 test the error flag, which a sloppy range test would raise one step early or late. Every input combination is also checked for a dash on all four displays during an error, a leading zero on the tens display, and a correct segment pattern for each digit.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
   localparam int unsigned SEG_W   = 7;
   localparam int unsigned DIGIT_W = 4;
   typedef logic [SEG_W-1:0] seg_t;
   // active-high dash: only segment g
   localparam seg_t SEG_DASH_HI = 7'b100_0000;
endpackage

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] s_out,
   output logic             c_out
);
   logic [WIDTH:0] carry;
   assign carry[0] = c_in;

   for (genvar k = 0; k < WIDTH; k++) begin : g_stage
      assign s_out[k]   = a_in[k] ^ b_in[k] ^ carry[k];
      assign carry[k+1] = (a_in[k] & b_in[k]) | (carry[k] & (a_in[k] ^ b_in[k]));
   end

   assign c_out = carry[WIDTH];
endmodule

// File: rtl/bcd_sum_correct.sv
module bcd_sum_correct #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] bin_sum,
   input  logic             bin_cout,
   output logic [WIDTH-1:0] tens,
   output logic [WIDTH-1:0] ones
);
   localparam logic [WIDTH-1:0] ADJUST = WIDTH'(6);
   logic over_nine;

   // a carry out means 16..19; otherwise 10..15 have bit3 and bit2 or bit1
   assign over_nine = bin_cout | (bin_sum[3] & (bin_sum[2] | bin_sum[1]));

   always_comb begin
      tens = '0;
      ones = bin_sum;
      if (over_nine) begin
         tens = WIDTH'(1);
         ones = bin_sum + ADJUST;
      end
   end
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
   import bcd_add_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic [DIGIT_W-1:0] digit,
   input  logic               force_dash,
   output seg_t               seg
);
   seg_t lit;

   always_comb begin
      unique case (digit)
         4'd0:    lit = 7'b011_1111;
         4'd1:    lit = 7'b000_0110;
         4'd2:    lit = 7'b101_1011;
         4'd3:    lit = 7'b100_1111;
         4'd4:    lit = 7'b110_0110;
         4'd5:    lit = 7'b110_1101;
         4'd6:    lit = 7'b111_1101;
         4'd7:    lit = 7'b000_0111;
         4'd8:    lit = 7'b111_1111;
         4'd9:    lit = 7'b110_1111;
         default: lit = SEG_DASH_HI;
      endcase
      if (force_dash) lit = SEG_DASH_HI;
   end

   if (ACTIVE_LOW) begin : g_low
      assign seg = ~lit;
   end else begin : g_high
      assign seg = lit;
   end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
   import bcd_add_pkg::*;
#(
   parameter int unsigned W         = DIGIT_W,
   parameter bit          SEG_ACT_LO = 1'b1
) (
   input  logic [W-1:0]     x_in,
   input  logic [W-1:0]     y_in,
   input  logic             cin,
   output logic [W-1:0]     raw_sum,
   output logic             raw_cout,
   output logic [W-1:0]     sum_tens,
   output logic [W-1:0]     sum_ones,
   output logic             digit_err,
   output logic [SEG_W-1:0] seg_x,
   output logic [SEG_W-1:0] seg_y,
   output logic [SEG_W-1:0] seg_tens,
   output logic [SEG_W-1:0] seg_ones
);
   localparam logic [W-1:0] MAX_DIGIT = W'(9);

   if (W != DIGIT_W) begin : g_bad_width
      $error("bcd_digit_adder: W must equal %0d", DIGIT_W);
   end

   bcd_ripple_adder #(.WIDTH(W)) i_adder (
      .a_in (x_in), .b_in (y_in), .c_in (cin),
      .s_out(raw_sum), .c_out(raw_cout)
   );

   bcd_sum_correct #(.WIDTH(W)) i_correct (
      .bin_sum(raw_sum), .bin_cout(raw_cout),
      .tens(sum_tens), .ones(sum_ones)
   );

   assign digit_err = (x_in > MAX_DIGIT) | (y_in > MAX_DIGIT);

   logic [W-1:0] disp_digit [4];
   seg_t         disp_seg   [4];
   assign disp_digit[0] = x_in;
   assign disp_digit[1] = y_in;
   assign disp_digit[2] = sum_tens;
   assign disp_digit[3] = sum_ones;

   for (genvar d = 0; d < 4; d++) begin : g_disp
      bcd_seg_decoder #(.ACTIVE_LOW(SEG_ACT_LO)) i_dec (
         .digit(disp_digit[d]), .force_dash(digit_err), .seg(disp_seg[d])
      );
   end

   assign seg_x    = disp_seg[0];
   assign seg_y    = disp_seg[1];
   assign seg_tens = disp_seg[2];
   assign seg_ones = disp_seg[3];
endmodule

// File: rtl/bcd_digit_adder_chk.sv
module bcd_digit_adder_chk (
   input logic [3:0] x_in,
   input logic [3:0] y_in,
   input logic       cin,
   input logic [3:0] raw_sum,
   input logic       raw_cout,
   input logic [3:0] sum_tens,
   input logic [3:0] sum_ones,
   input logic       digit_err,
   input logic [6:0] seg_x,
   input logic [6:0] seg_y,
   input logic [6:0] seg_tens,
   input logic [6:0] seg_ones
);
   logic [4:0] total;
   logic       known;
   assign total = 5'(x_in) + 5'(y_in) + 5'(cin);
   assign known = !$isunknown({x_in, y_in, cin});

   always_comb begin
      if (known) begin
         AST_RAW_SUM: assert ({raw_cout, raw_sum} == total); // R1
         AST_ERR_FLAG: assert (digit_err == ((x_in > 4'd9) || (y_in > 4'd9))); // R4
         AST_LOW_SUM: assert (digit_err || total > 5'd9 || (sum_tens == 4'd0 && 5'(sum_ones) == total)); // R2
         AST_HIGH_SUM: assert (digit_err || total <= 5'd9 || (sum_tens == 4'd1 && 5'(sum_ones) + 5'd10 == total)); // R3
         AST_ERR_DASH: assert (!digit_err || (seg_x == 7'h3F && seg_y == 7'h3F && seg_tens == 7'h3F && seg_ones == 7'h3F)); // R7
         AST_TENS_SHOWN: assert (digit_err || seg_tens != 7'h7F); // R6
      end
   end
endmodule

bind bcd_digit_adder bcd_digit_adder_chk i_chk (.*);

// File: tb/test_bcd_digit_adder.sv
module test_bcd_digit_adder;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [3:0] x, y;
   logic       c;
   logic [3:0] raw_sum, sum_tens, sum_ones;
   logic       raw_cout, digit_err;
   logic [6:0] seg_x, seg_y, seg_tens, seg_ones;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   bcd_digit_adder i_bcd_digit_adder (
      .x_in(x), .y_in(y), .cin(c),
      .raw_sum(raw_sum), .raw_cout(raw_cout),
      .sum_tens(sum_tens), .sum_ones(sum_ones), .digit_err(digit_err),
      .seg_x(seg_x), .seg_y(seg_y), .seg_tens(seg_tens), .seg_ones(seg_ones)
   );

   // directed vectors: {x, y, cin, expected tens, expected ones}
   localparam int NV = 10;
   localparam logic [16:0] VEC [NV] = '{
      {4'd0, 4'd0, 1'b0, 4'd0, 4'd0},
      {4'd0, 4'd0, 1'b1, 4'd0, 4'd1},
      {4'd4, 4'd5, 1'b0, 4'd0, 4'd9},
      {4'd4, 4'd5, 1'b1, 4'd1, 4'd0},
      {4'd7, 4'd8, 1'b0, 4'd1, 4'd5},
      {4'd8, 4'd8, 1'b0, 4'd1, 4'd6},
      {4'd9, 4'd8, 1'b0, 4'd1, 4'd7},
      {4'd9, 4'd9, 1'b0, 4'd1, 4'd8},
      {4'd9, 4'd9, 1'b1, 4'd1, 4'd9},
      {4'd6, 4'd3, 1'b0, 4'd0, 4'd9}
   };

   localparam logic [6:0] PAT [10] = '{
      7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78, 7'h00, 7'h10
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s x=%0d y=%0d c=%0d actual=%0h expected=%0h", req, x, y, c, act, exp);
      end
   endtask

   task automatic apply(input int xa, input int ya, input int ca);
      @(posedge clk);
      x = 4'(xa); y = 4'(ya); c = 1'(ca);
      @(negedge clk);
   endtask

   task automatic check_full(input int xa, input int ya, input int ca);
      int t;
      bit bad;
      apply(xa, ya, ca);
      t   = xa + ya + ca;
      bad = (xa > 9) || (ya > 9);
      chk("R1", {raw_cout, raw_sum}, t);
      chk("R4", digit_err, bad);
      if (bad) begin
         chk("R7", {seg_x, seg_y, seg_tens, seg_ones}, {7'h3F, 7'h3F, 7'h3F, 7'h3F});
      end else begin
         if (t <= 9) chk("R2", {sum_tens, sum_ones}, {4'(t / 10), 4'(t % 10)});
         else        chk("R3", {sum_tens, sum_ones}, {4'(t / 10), 4'(t % 10)});
         chk("R5", {seg_x, seg_y}, {PAT[xa], PAT[ya]});
         chk("R6", {seg_tens, seg_ones}, {PAT[t / 10], PAT[t % 10]});
      end
   endtask

   initial begin
      x = '0; y = '0; c = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: zero inputs give 00 on the sum and a leading-zero display
      chk("R2", {sum_tens, sum_ones, 3'b000, digit_err}, 0);
      chk("R6", seg_tens, 7'h40);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         apply(int'(VEC[i][16:13]), int'(VEC[i][12:9]), int'(VEC[i][8]));
         if (int'(VEC[i][16:13]) + int'(VEC[i][12:9]) + int'(VEC[i][8]) > 9)
            chk("R3", {sum_tens, sum_ones}, VEC[i][7:0]);
         else
            chk("R2", {sum_tens, sum_ones}, VEC[i][7:0]);
      end

      // error boundaries: 9 valid, 10 invalid, 15 with raw wrap
      check_full(9, 9, 1);
      check_full(10, 0, 0);
      check_full(0, 10, 1);
      check_full(15, 15, 1);

      for (int xa = 0; xa < 16; xa++)
         for (int ya = 0; ya < 16; ya++)
            for (int ca = 0; ca < 2; ca++)
               check_full(xa, ya, ca);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (50000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule